// File: doc/BRIEF.md
# Ethernet MAC Interrupt Status and Soft-Reset Controller

This block is the control-register core of an Ethernet MAC. It holds a command word, an interrupt enable word and a two-sided interrupt status word. Single-cycle pulses from the transmit and receive engines latch into the status word, and two interrupt lines leave the block: one for the transmit half, one for the receive half. The same register space also holds the ring start addresses, FIFO threshold, receive frame limit, management address, missed-frame count and an address-match table, each with its power-up value. The engines that use these values are not part of this block.

Software reaches the registers through a plain 32-bit bus that is indexed by word, so byte address = index × 4. A write takes effect at the next rising clock edge. Read data is combinational from the current index. Setting the reset bit of the command word starts a timed software reset. During the first phase every register reads as zero. During the second phase the registers hold their power-up values and the reset bit still reads as one. After that the bit clears by itself. The bus has no back-pressure: every write is taken or dropped in the cycle it is presented, and the event inputs are pulses with no handshake.

Top module: `mac_irq_ctrl`

## Requirements
- R1: After `rst_n` the register indices read: 0 command = 0, 1 enable = 0, 2 status = 0, 3 transmit ring start = 0xFFFFFFFC, 4 receive ring start = 0xFFFFFFFC, 5 FIFO threshold = 0x00000101, 6 receive frame limit = 0x00000800, 7 management address = 0x00900000, 8 missed-frame count = 0x00007FFF, and every address-match entry (indices 16 to 16+2·MATCH_ENTRIES−1) = 0.
- R2: The enable register (index 1) is fully read/write. In the status register (index 2), writing a 1 to a bit clears it and writing a 0 leaves it unchanged.
- R3: A high bit on `tx_evt[i]` sets status bit 16+i, and a high bit on `rx_evt[i]` sets status bit i. The bit is visible from the cycle after the pulse. An event in the same cycle as a clearing write to that bit wins, and the bit stays set.
- R4: `irq_tx` is the OR of status bits 31..16 ANDed with their enable bits. `irq_rx` is the same for bits 15..0. Status bits whose enable is off never raise a line.
- R5: A write to index 0 with bit 24 set starts a software reset. For the next BLANK_CYCLES cycles every index reads 0.
- R6: For the SETTLE_CYCLES cycles that follow, index 0 reads with bit 24 = 1 and all other registers show their R1 values. After that, bit 24 reads 0.
- R7: From the start write until the sequence ends, bus writes and event pulses are ignored and both interrupt lines stay low. Afterwards every register holds its R1 value, including registers written before the reset.
- R8: The two ring start registers (indices 3 and 4) always read 0 in bits 1..0.
- R9: Indices 9 to 15 and those above the address-match table read 0, and writes to them have no effect.
- R10: Each address-match entry and general register (indices 5..8) stores and returns any written 32-bit value. Index 0 stores all bits except bit 24.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Word index of the register accessed |
| bus_we | input | 1 | Write strobe, one write per cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| tx_evt | input | 16 | Transmit event pulses, bit i sets status bit 16+i |
| rx_evt | input | 16 | Receive event pulses, bit i sets status bit i |
| irq_tx | output | 1 | Transmit interrupt line |
| irq_rx | output | 1 | Receive interrupt line |

## Verification
A wrong status or enable bit shows up on `irq_tx` or `irq_rx` in the cycle after the event or write that set it. It also shows on a read of index 2 in that same cycle. A wrong phase or count in the reset sequencer shows as the blank window or the bit-24 window being one or more cycles too long or too short. A register that failed to restore shows on its first read after the sequence ends. The reference model in the bench predicts the read data and both interrupt lines for every cycle, including random traffic with occasional resets. Any divergence is therefore reported in the cycle it first reaches a port.

// File: rtl/mac_irq_pkg.sv
package mac_irq_pkg;
  localparam int DATA_W     = 32;
  localparam int HALF_W     = DATA_W / 2;
  localparam int IDX_CMD    = 0;
  localparam int IDX_IEN    = 1;
  localparam int IDX_STAT   = 2;
  localparam int GEN_BASE   = 3;
  localparam int GEN_COUNT  = 6;
  localparam int TABLE_BASE = 16;
  localparam int RESET_BIT  = 24;

  typedef enum logic [1:0] {PH_IDLE, PH_BLANK, PH_SETTLE} rst_phase_e;

  // Power-up value of a register-bank slot (slots 0..5 are general, the rest the match table)
  function automatic logic [DATA_W-1:0] slot_reset(input int s);
    case (s)
      0, 1:    return 32'hFFFF_FFFC;
      2:       return 32'h0000_0101;
      3:       return 32'h0000_0800;
      4:       return 32'h0090_0000;
      5:       return 32'h0000_7FFF;
      default: return '0;
    endcase
  endfunction

  function automatic logic [DATA_W-1:0] slot_wmask(input int s);
    return (s < 2) ? 32'hFFFF_FFFC : 32'hFFFF_FFFF;
  endfunction
endpackage

// File: rtl/mac_rst_seq.sv
module mac_rst_seq
  import mac_irq_pkg::*;
#(
  parameter int BLANK_CYCLES  = 16,
  parameter int SETTLE_CYCLES = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic blank,
  output logic settle,
  output logic pending
);
  localparam int MAXC  = (BLANK_CYCLES > SETTLE_CYCLES) ? BLANK_CYCLES : SETTLE_CYCLES;
  localparam int CNT_W = $clog2(MAXC + 1);

  rst_phase_e       phase_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
    end else begin
      unique case (phase_q)
        PH_IDLE: if (start) begin
          phase_q <= PH_BLANK;
          cnt_q   <= CNT_W'(BLANK_CYCLES - 1);
        end
        PH_BLANK: if (cnt_q == '0) begin
          phase_q <= PH_SETTLE;
          cnt_q   <= CNT_W'(SETTLE_CYCLES - 1);
        end else begin
          cnt_q <= cnt_q - 1'b1;
        end
        PH_SETTLE: if (cnt_q == '0) phase_q <= PH_IDLE;
                   else             cnt_q   <= cnt_q - 1'b1;
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  assign blank   = (phase_q == PH_BLANK);
  assign settle  = (phase_q == PH_SETTLE);
  assign pending = (phase_q != PH_IDLE);
endmodule

// File: rtl/mac_reg_bank.sv
module mac_reg_bank
  import mac_irq_pkg::*;
#(
  parameter int NUM_SLOTS = 38,
  localparam int SLOT_W   = $clog2(NUM_SLOTS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              we,
  input  logic [SLOT_W-1:0] wslot,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] q [NUM_SLOTS]
);
  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    localparam logic [DATA_W-1:0] RV = slot_reset(s);
    localparam logic [DATA_W-1:0] WM = slot_wmask(s);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                q[s] <= RV;
      else if (clr)                              q[s] <= RV;
      else if (we && (wslot == SLOT_W'(s)))      q[s] <= wdata & WM;
    end
  end
endmodule

// File: rtl/mac_irq_unit.sv
module mac_irq_unit
  import mac_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              ien_we,
  input  logic              stat_we,
  input  logic [DATA_W-1:0] wdata,
  input  logic [HALF_W-1:0] tx_evt,
  input  logic [HALF_W-1:0] rx_evt,
  output logic [DATA_W-1:0] ien_q,
  output logic [DATA_W-1:0] stat_q,
  output logic              irq_tx,
  output logic              irq_rx
);
  logic [DATA_W-1:0] clr_mask;
  logic [1:0]        irq_half;

  assign clr_mask = stat_we ? wdata : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ien_q  <= '0;
      stat_q <= '0;
    end else if (clr) begin
      ien_q  <= '0;
      stat_q <= '0;
    end else begin
      if (ien_we) ien_q <= wdata;
      // new events are ORed after the clear so they survive a same-cycle clear
      stat_q <= (stat_q & ~clr_mask) | {tx_evt, rx_evt};
    end
  end

  for (genvar h = 0; h < 2; h++) begin : g_half
    assign irq_half[h] = |(stat_q[h*HALF_W +: HALF_W] & ien_q[h*HALF_W +: HALF_W]);
  end

  assign irq_rx = irq_half[0];
  assign irq_tx = irq_half[1];
endmodule

// File: rtl/mac_irq_ctrl.sv
module mac_irq_ctrl
  import mac_irq_pkg::*;
#(
  parameter int MATCH_ENTRIES = 16,
  parameter int BLANK_CYCLES  = 16,
  parameter int SETTLE_CYCLES = 4,
  parameter int ADDR_W        = $clog2(TABLE_BASE + 2 * MATCH_ENTRIES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [15:0]       tx_evt,
  input  logic [15:0]       rx_evt,
  output logic              irq_tx,
  output logic              irq_rx
);
  localparam int TABLE_REGS = 2 * MATCH_ENTRIES;
  localparam int NUM_SLOTS  = GEN_COUNT + TABLE_REGS;
  localparam int SLOT_W     = $clog2(NUM_SLOTS);
  localparam logic [DATA_W-1:0] CMD_WMASK = ~(DATA_W'(1) << RESET_BIT);

  logic              rst_blank, rst_settle, rst_pending;
  logic              start, clr, wr_ok;
  logic [DATA_W-1:0] cmd_q, ien_q, stat_q;
  logic [DATA_W-1:0] bank_q [NUM_SLOTS];
  logic              slot_hit;
  logic [SLOT_W-1:0] slot;
  logic [DATA_W-1:0] rd_mux;
  int                ai;

  assign ai      = int'(bus_addr);
  assign start   = bus_we && (ai == IDX_CMD) && bus_wdata[RESET_BIT] && !rst_pending;
  assign clr     = rst_pending || start;
  assign wr_ok   = bus_we && !rst_pending;

  mac_rst_seq #(.BLANK_CYCLES(BLANK_CYCLES), .SETTLE_CYCLES(SETTLE_CYCLES)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start),
    .blank(rst_blank), .settle(rst_settle), .pending(rst_pending)
  );

  // bus index to bank slot
  always_comb begin
    slot_hit = 1'b0;
    slot     = '0;
    if (ai >= GEN_BASE && ai < GEN_BASE + GEN_COUNT) begin
      slot_hit = 1'b1;
      slot     = SLOT_W'(ai - GEN_BASE);
    end else if (ai >= TABLE_BASE && ai < TABLE_BASE + TABLE_REGS) begin
      slot_hit = 1'b1;
      slot     = SLOT_W'(ai - TABLE_BASE + GEN_COUNT);
    end
  end

  mac_reg_bank #(.NUM_SLOTS(NUM_SLOTS)) u_bank (
    .clk(clk), .rst_n(rst_n), .clr(clr),
    .we(wr_ok && slot_hit), .wslot(slot), .wdata(bus_wdata), .q(bank_q)
  );

  mac_irq_unit u_irq (
    .clk(clk), .rst_n(rst_n), .clr(clr),
    .ien_we(wr_ok && ai == IDX_IEN), .stat_we(wr_ok && ai == IDX_STAT),
    .wdata(bus_wdata), .tx_evt(tx_evt), .rx_evt(rx_evt),
    .ien_q(ien_q), .stat_q(stat_q), .irq_tx(irq_tx), .irq_rx(irq_rx)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        cmd_q <= '0;
    else if (clr)                      cmd_q <= '0;
    else if (wr_ok && ai == IDX_CMD)   cmd_q <= bus_wdata & CMD_WMASK;
  end

  always_comb begin
    rd_mux = '0;
    if (ai == IDX_CMD)       rd_mux = cmd_q | (DATA_W'(rst_settle) << RESET_BIT);
    else if (ai == IDX_IEN)  rd_mux = ien_q;
    else if (ai == IDX_STAT) rd_mux = stat_q;
    else if (slot_hit)       rd_mux = bank_q[slot];
  end

  assign bus_rdata = rst_blank ? '0 : rd_mux;
endmodule

// File: rtl/mac_irq_ctrl_chk.sv
module mac_irq_ctrl_chk #(
  parameter int ADDR_W = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_we,
  input logic [31:0]       bus_wdata,
  input logic [31:0]       bus_rdata,
  input logic [15:0]       tx_evt,
  input logic [15:0]       rx_evt,
  input logic              irq_tx,
  input logic              irq_rx,
  input logic              rst_blank,
  input logic              rst_pending,
  input logic [31:0]       ien_q,
  input logic [31:0]       stat_q
);
  logic go;
  assign go = bus_we && (int'(bus_addr) == 0) && bus_wdata[24] && !rst_pending;

  assert_blank_after_start_R5: assert property (@(posedge clk) disable iff (!rst_n)
    go |=> (bus_rdata == 32'h0));

  assert_settle_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_pending && !rst_blank && int'(bus_addr) == 0) |-> bus_rdata[24]);

  assert_irq_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rst_pending |-> (!irq_tx && !irq_rx));

  assert_event_latched_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!rst_pending && !go) |=> ((stat_q & $past({tx_evt, rx_evt})) == $past({tx_evt, rx_evt})));

  assert_w1c_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!rst_pending && !go && bus_we && int'(bus_addr) == 2)
      |=> ((stat_q & $past(bus_wdata) & ~$past({tx_evt, rx_evt})) == 32'h0));

  assert_irq_tx_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (|(stat_q[31:16] & ien_q[31:16])) |-> irq_tx);

  assert_irq_rx_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (|(stat_q[15:0] & ien_q[15:0])) |-> irq_rx);

  assert_ring_align_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(bus_addr) == 3 || int'(bus_addr) == 4) |-> (bus_rdata[1:0] == 2'b00));
endmodule

bind mac_irq_ctrl mac_irq_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tx_evt(tx_evt), .rx_evt(rx_evt),
  .irq_tx(irq_tx), .irq_rx(irq_rx), .rst_blank(rst_blank), .rst_pending(rst_pending),
  .ien_q(ien_q), .stat_q(stat_q)
);

// File: tb/mac_irq_ctrl_tb.sv
`timescale 1ns/1ps
module mac_irq_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int ENTRIES    = 16;
  localparam int BLANK      = 16;
  localparam int SETTLE     = 4;
  localparam int AW         = 6;
  localparam int WATCHDOG   = 100000;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic          bus_we = 1'b0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic [15:0]   tx_evt = '0, rx_evt = '0;
  logic          irq_tx, irq_rx;

  int n_checks = 0, n_fail = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mac_irq_ctrl #(.MATCH_ENTRIES(ENTRIES), .BLANK_CYCLES(BLANK), .SETTLE_CYCLES(SETTLE)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .tx_evt(tx_evt), .rx_evt(rx_evt), .irq_tx(irq_tx), .irq_rx(irq_rx)
  );

  // ---------------- reference model ----------------
  logic [31:0] m_reg [64];
  int m_phase = 0, m_cnt = 0;

  function automatic logic [31:0] rv(input int a);
    case (a)
      3, 4: return 32'hFFFF_FFFC;
      5:    return 32'h0000_0101;
      6:    return 32'h0000_0800;
      7:    return 32'h0090_0000;
      8:    return 32'h0000_7FFF;
      default: return 32'h0;
    endcase
  endfunction

  function automatic bit mapped(input int a);
    return (a <= 8) || (a >= 16 && a < 16 + 2*ENTRIES);
  endfunction

  function automatic logic [31:0] wmask(input int a);
    if (a == 0) return 32'hFEFF_FFFF;
    if (a == 3 || a == 4) return 32'hFFFF_FFFC;
    return 32'hFFFF_FFFF;
  endfunction

  task automatic m_restore();
    for (int a = 0; a < 64; a++) m_reg[a] = rv(a);
  endtask

  function automatic logic [31:0] m_read(input int a);
    if (m_phase == 1) return 32'h0;
    if (a == 0) return m_reg[0] | ((m_phase == 2) ? 32'h0100_0000 : 32'h0);
    return m_reg[a];
  endfunction

  task automatic m_step(input bit we, input int a, input logic [31:0] wd,
                        input logic [15:0] tx, input logic [15:0] rx);
    if (m_phase == 0) begin
      if (we && a == 0 && wd[24]) begin
        m_phase = 1; m_cnt = BLANK - 1; m_restore();
      end else begin
        logic [31:0] st;
        st = m_reg[2];
        if (we && a == 2) st = st & ~wd;
        if (we && a != 2 && mapped(a)) m_reg[a] = wd & wmask(a);
        m_reg[2] = st | {tx, rx};
      end
    end else begin
      m_restore();
      if (m_cnt == 0) begin
        if (m_phase == 1) begin m_phase = 2; m_cnt = SETTLE - 1; end
        else m_phase = 0;
      end else m_cnt--;
    end
  endtask

  // ---------------- checking ----------------
  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  // one clock: drive, compare against the model, advance the model
  task automatic cyc(input bit we, input int a, input logic [31:0] wd,
                     input logic [15:0] tx, input logic [15:0] rx, input string tag);
    logic eirq_t, eirq_r;
    @(negedge clk);
    bus_we = we; bus_addr = AW'(a); bus_wdata = wd; tx_evt = tx; rx_evt = rx;
    #1;
    eirq_t = (m_phase == 0) && (|(m_reg[2][31:16] & m_reg[1][31:16]));
    eirq_r = (m_phase == 0) && (|(m_reg[2][15:0] & m_reg[1][15:0]));
    chk({tag, " model rdata"}, bus_rdata, m_read(a));
    chk({tag, " model irq"}, {30'h0, irq_tx, irq_rx}, {30'h0, eirq_t, eirq_r});
    m_step(we, a, wd, tx, rx);
  endtask

  task automatic rd(input int a, input logic [31:0] exp, input string tag);
    cyc(0, a, 32'h0, 16'h0, 16'h0, tag);
    chk(tag, bus_rdata, exp);
  endtask

  task automatic wr(input int a, input logic [31:0] d, input string tag);
    cyc(1, a, d, 16'h0, 16'h0, tag);
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  // ---------------- stimulus ----------------
  initial begin
    m_restore();
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1 power-up values
    rd(0, 32'h0, "R1 cmd");
    rd(1, 32'h0, "R1 enable");
    rd(2, 32'h0, "R1 status");
    rd(3, 32'hFFFF_FFFC, "R1 tx ring");
    rd(4, 32'hFFFF_FFFC, "R1 rx ring");
    rd(5, 32'h0000_0101, "R1 fifo thr");
    rd(6, 32'h0000_0800, "R1 frame limit");
    rd(7, 32'h0090_0000, "R1 mgmt addr");
    rd(8, 32'h0000_7FFF, "R1 missed");
    rd(16, 32'h0, "R1 table first");
    rd(47, 32'h0, "R1 table last");

    // R9 unmapped
    wr(12, 32'hDEAD_BEEF, "R9 write");
    rd(12, 32'h0, "R9 read 12");
    wr(50, 32'h1234_5678, "R9 write hi");
    rd(50, 32'h0, "R9 read 50");

    // R10 storage
    wr(16, 32'hA5A5_0001, "R10");
    wr(47, 32'h5A5A_FFFF, "R10");
    wr(6, 32'h0000_05EE, "R10");
    wr(0, 32'h0000_0103, "R10");
    rd(16, 32'hA5A5_0001, "R10 table first");
    rd(47, 32'h5A5A_FFFF, "R10 table last");
    rd(6, 32'h0000_05EE, "R10 general");
    rd(0, 32'h0000_0103, "R10 cmd");

    // R8 ring alignment
    wr(3, 32'h1234_5677, "R8");
    rd(3, 32'h1234_5674, "R8 tx ring");
    wr(4, 32'hFFFF_FFFF, "R8");
    rd(4, 32'hFFFF_FFFC, "R8 rx ring");

    // R2 enable, R3 events, R4 lines
    wr(1, 32'h0005_0011, "R2");
    rd(1, 32'h0005_0011, "R2 enable rw");
    cyc(0, 2, 0, 16'h0004, 16'h0000, "R3 tx event");
    rd(2, 32'h0004_0000, "R3 tx status bit18");
    chk("R4 irq_tx set", {31'h0, irq_tx}, 32'h1);
    chk("R4 irq_rx clear", {31'h0, irq_rx}, 32'h0);
    cyc(0, 2, 0, 16'h0000, 16'h0010, "R3 rx event");
    rd(2, 32'h0004_0010, "R3 rx status bit4");
    chk("R4 irq_rx set", {31'h0, irq_rx}, 32'h1);
    wr(2, 32'h0004_0000, "R2 w1c");
    rd(2, 32'h0000_0010, "R2 w1c tx half");
    chk("R4 irq_tx drop", {31'h0, irq_tx}, 32'h0);
    cyc(1, 2, 32'h0000_0010, 16'h0, 16'h0010, "R3 race");
    rd(2, 32'h0000_0010, "R3 event wins over clear");
    wr(2, 32'h0000_0010, "R2 clear");
    cyc(0, 2, 0, 16'h0080, 16'h0400, "R4 masked events");
    rd(2, 32'h0080_0400, "R3 masked status");
    chk("R4 masked no irq", {30'h0, irq_tx, irq_rx}, 32'h0);

    // R5..R7 soft reset
    wr(5, 32'h0000_0777, "R7 prep");
    wr(2, 32'hFFFF_FFFF, "R7 prep");
    cyc(0, 1, 0, 16'h0001, 16'h0001, "R7 prep events");
    wr(0, 32'h0100_0000, "R5 start");
    for (int i = 0; i < BLANK; i++) begin
      cyc(1, (i % 2) ? 1 : 5, 32'hFFFF_FFFF, 16'hFFFF, 16'hFFFF, "R7 ignored");
      chk("R5 blank read", bus_rdata, 32'h0);
      chk("R7 irq low", {30'h0, irq_tx, irq_rx}, 32'h0);
    end
    for (int i = 0; i < SETTLE; i++) begin
      cyc(1, 0, 32'h0000_00FF, 16'h0, 16'h0, "R7 ignored settle");
      chk("R6 settle flag", bus_rdata, 32'h0100_0000);
    end
    rd(0, 32'h0, "R6 flag cleared");
    rd(5, 32'h0000_0101, "R7 restored");
    rd(1, 32'h0, "R7 enable restored");
    rd(2, 32'h0, "R7 events dropped");
    rd(16, 32'h0, "R7 table restored");
    rd(3, 32'hFFFF_FFFC, "R7 ring restored");

    // random traffic against the model
    for (int n = 0; n < 4000; n++) begin
      int a;
      logic [31:0] d;
      bit we;
      a  = $urandom_range(0, 63);
      if ($urandom_range(0, 3) == 0) a = $urandom_range(0, 2);
      d  = $urandom;
      we = ($urandom_range(0, 2) == 0);
      if (a == 0 && $urandom_range(0, 19) != 0) d[24] = 1'b0;
      cyc(we, a, d, 16'($urandom & $urandom & $urandom), 16'($urandom & $urandom & $urandom),
          "R2 R4 random");
    end

    done = 1;
    $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule